// File: doc/BRIEF.md
# Periodic Serial Sample Framer

The block sends one fixed-width sample word per frame to a host over a one-bit serial line. A free-running counter on the master clock divides it down to the frame rate: 1625 master cycles for an 8 kHz frame from a 13 MHz clock. At each frame boundary the framer copies the word most recently placed in its holding register into a shift register. On the next serial-clock enable it raises a frame-sync strobe for one serial-clock period. After that it shifts the word out most significant bit first, one bit per serial-clock enable. The host samples each bit on the falling edge of its serial clock, while the data changes on the rising edge.

Transmission is gated by two power-enable bits taken from a configuration register: a digital enable (control bit 5) and an analog enable (control bit 4). Output starts only when both bits are 1, and only after a start-up delay of a set number of frame periods. If either bit is cleared, the word already on the line is completed and no further frame begins. If the sample source has not loaded a new word since the last frame, the previous word is sent again and an underrun flag is raised for that frame.

Top module: `serial_frame_tx`

## Requirements
- R1: While output is running, consecutive rising edges of `fsync` are exactly FRAME_CYCLES master-clock cycles apart.
- R2: `fsync` rises once per frame on a serial-clock enable and falls on the next serial-clock enable, so it is high for exactly one serial-clock period.
- R3: The WORD_W data bits appear on `sdo` MSB first. The first bit is driven on the serial-clock enable after the one that raised `fsync`, and each following bit is driven on the next enable.
- R4: No frame is sent unless `pwr_dig` (control bit 5) and `pwr_ana` (control bit 4) are both 1. Either bit alone produces no `fsync`.
- R5: After both enables become 1, the first `fsync` comes at the STARTUP_FRAMES-th frame boundary. It is therefore more than (STARTUP_FRAMES-1)*FRAME_CYCLES and at most STARTUP_FRAMES*FRAME_CYCLES plus two serial-clock periods later.
- R6: Clearing either enable lets the word in progress finish with all its bits. No further `fsync` follows, and the next start needs the full start-up delay again.
- R7: A word loaded with `smp_load` is sent in the next frame with `underrun` = 0. If no load occurred since the previous frame, the previous word is sent again with `underrun` = 1 for that frame.
- R8: During and just after reset, `sdo`, `fsync` and `underrun` are 0.
- R9: `sdo` is 0 whenever no data bit is being driven, including the serial-clock period in which `fsync` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_en | input | 1 | One-cycle strobe marking each serial-clock rising edge |
| smp_data | input | WORD_W | Parallel sample word |
| smp_load | input | 1 | Strobe that writes `smp_data` into the holding register |
| pwr_dig | input | 1 | Digital power enable (control bit 5) |
| pwr_ana | input | 1 | Analog power enable (control bit 4) |
| sdo | output | 1 | Serial data, MSB first |
| fsync | output | 1 | Output frame sync, one serial-clock period per frame |
| underrun | output | 1 | The word of the current frame is a repeat |

## Verification
A wrong frame counter shows as an `fsync` spacing different from FRAME_CYCLES at the second frame of a run. A wrong bit counter or shift register corrupts the word the scoreboard collects within one frame. A gate state that leaves the off state too early, or forgets to return to it, shows as an `fsync` during the single-enable interval or during the start-up window, or as one after an enable is dropped, within one frame period. A stale freshness flag shows as a wrong `underrun` value on the first repeated or freshly loaded word.

// File: rtl/sft_pkg.sv
package sft_pkg;
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_WARM = 2'd1,
        GATE_RUN  = 2'd2
    } gate_e;
endpackage

// File: rtl/sft_frame_timer.sv
module sft_frame_timer #(
    parameter int FRAME_CYCLES = 1625
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST) tmr_d.cnt = '0;
        else                   tmr_d.cnt = tmr_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = (tmr_q.cnt == LAST);

    // R1: the count never leaves its period
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);
    // R1: a boundary is followed by a restart from zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (tmr_q.cnt == '0));
endmodule

// File: rtl/sft_start_gate.sv
module sft_start_gate
    import sft_pkg::*;
#(
    parameter int STARTUP_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_dig_i,
    input  logic en_ana_i,
    output logic launch_o
);
    localparam int SCW = (STARTUP_FRAMES > 1) ? $clog2(STARTUP_FRAMES) : 1;
    localparam logic [SCW-1:0] SLAST = SCW'(STARTUP_FRAMES - 1);

    typedef struct packed {
        gate_e          st;
        logic [SCW-1:0] cnt;
    } gate_t;

    gate_t g_d, g_q;
    logic  both;

    assign both = en_dig_i & en_ana_i;

    always_comb begin
        g_d      = g_q;
        launch_o = 1'b0;
        unique case (g_q.st)
            GATE_OFF: begin
                if (both) begin
                    g_d.st  = GATE_WARM;
                    g_d.cnt = '0;
                end
            end
            GATE_WARM: begin
                if (!both) begin
                    g_d.st = GATE_OFF;
                end else if (tick_i) begin
                    if (g_q.cnt == SLAST) begin
                        g_d.st   = GATE_RUN;
                        launch_o = 1'b1;
                    end else begin
                        g_d.cnt = g_q.cnt + SCW'(1);
                    end
                end
            end
            GATE_RUN: begin
                if (tick_i) begin
                    if (both) launch_o = 1'b1;
                    else      g_d.st   = GATE_OFF;
                end
            end
            default: g_d.st = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.st  <= GATE_OFF;
            g_q.cnt <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    // R4: a frame starts only with both enables set
    a_r4_launch_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (en_dig_i && en_ana_i));
    // R5: the off state never starts a frame
    a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == GATE_OFF) |-> !launch_o);
    // R5: the warm-up count stays within the start-up delay
    a_r5_warm_count: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.st == GATE_WARM) |-> (g_q.cnt <= SLAST));
    // R6: a dropped enable at a boundary returns to off
    a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((g_q.st == GATE_RUN) && tick_i && !both) |=> (g_q.st == GATE_OFF));
endmodule

// File: rtl/sft_word_shifter.sv
module sft_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en_i,
    input  logic              launch_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_data_i,
    output logic              sdo_o,
    output logic              fsync_o,
    output logic              underrun_o
);
    localparam int BW = $clog2(WORD_W + 1);
    localparam logic [BW-1:0] FULL = BW'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              fresh;
        logic [WORD_W-1:0] shreg;
        logic [BW-1:0]     bits;
        logic              pend;
        logic              fsync;
        logic              sdo;
        logic              under;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.hold  = load_data_i;
            s_d.fresh = 1'b1;
        end
        if (sclk_en_i) begin
            s_d.fsync = s_q.pend;
            s_d.pend  = 1'b0;
            if (s_q.bits != '0) begin
                s_d.sdo   = s_q.shreg[WORD_W-1];
                s_d.shreg = {s_q.shreg[WORD_W-2:0], 1'b0};
                s_d.bits  = s_q.bits - BW'(1);
            end else begin
                s_d.sdo = 1'b0;
            end
            if (s_q.pend) s_d.bits = FULL;
        end
        if (launch_i) begin
            s_d.shreg = s_q.hold;
            s_d.under = ~s_q.fresh;
            s_d.fresh = load_i;
            s_d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo_o      = s_q.sdo;
    assign fsync_o    = s_q.fsync;
    assign underrun_o = s_q.under;

    // R2: sync lasts one serial-clock period
    a_r2_fsync_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fsync && sclk_en_i) |=> !s_q.fsync);
    // R3: a raised sync is followed by a full word of bits
    a_r3_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.fsync) |-> (s_q.bits == FULL));
    // R9: sdo is low while sync is high
    a_r9_sdo_low_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fsync |-> !s_q.sdo);
    // R7: a frame without a new load clears freshness
    a_r7_fresh_used: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !load_i) |=> !s_q.fresh);
    // R1: the frame must be long enough to finish the previous word
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> ((s_q.bits == '0) && !s_q.pend));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int WORD_W         = 16,
    parameter int FRAME_CYCLES   = 1625,
    parameter int STARTUP_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic [WORD_W-1:0] smp_data,
    input  logic              smp_load,
    input  logic              pwr_dig,
    input  logic              pwr_ana,
    output logic              sdo,
    output logic              fsync,
    output logic              underrun
);
    logic frame_tick;
    logic launch;

    sft_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (frame_tick)
    );

    sft_start_gate #(.STARTUP_FRAMES(STARTUP_FRAMES)) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (frame_tick),
        .en_dig_i (pwr_dig),
        .en_ana_i (pwr_ana),
        .launch_o (launch)
    );

    sft_word_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_en_i   (sclk_en),
        .launch_i    (launch),
        .load_i      (smp_load),
        .load_data_i (smp_data),
        .sdo_o       (sdo),
        .fsync_o     (fsync),
        .underrun_o  (underrun)
    );
endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
    localparam int W  = 16;
    localparam int F  = 100;
    localparam int S  = 2;

    typedef struct {
        logic [W-1:0] d;
        bit           u;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_en = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         smp_load = 1'b0;
    logic         pwr_dig = 1'b0;
    logic         pwr_ana = 1'b0;
    logic         sdo, fsync, underrun;

    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    int  fs_count = 0;
    int  rise_cyc = 0;
    bit  period_en = 1'b0;
    bit  done = 1'b0;
    exp_t sb[$];

    serial_frame_tx #(.WORD_W(W), .FRAME_CYCLES(F), .STARTUP_FRAMES(S)) i_serial_frame_tx (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .smp_data(smp_data),
        .smp_load(smp_load), .pwr_dig(pwr_dig), .pwr_ana(pwr_ana),
        .sdo(sdo), .fsync(fsync), .underrun(underrun)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    initial forever begin
        @(negedge clk);
        sclk_en = ~sclk_en;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic load_word(input logic [W-1:0] d);
        @(negedge clk);
        smp_data = d;
        smp_load = 1'b1;
        @(negedge clk);
        smp_load = 1'b0;
        sb.push_back('{d: d, u: 1'b0});
    endtask

    // monitor: gathers each frame's word and compares it with the scoreboard
    initial begin
        bit           e;
        bit           fs_prev = 1'b0;
        bit           cap = 1'b0;
        bit           chk_fall = 1'b0;
        int           nb = 0;
        int           last_rise = 0;
        logic [W-1:0] word = '0;
        exp_t         x;
        forever begin
            @(posedge clk);
            e = sclk_en;
            @(negedge clk);
            if (!rst_n || !e) continue;
            if (chk_fall) begin
                check(fsync == 1'b0, "R2 fsync fall", fsync, 0);
                chk_fall = 1'b0;
            end
            if (fsync && !fs_prev) begin
                fs_count++;
                if (period_en) check(cyc - last_rise == F, "R1 period", cyc - last_rise, F);
                last_rise = cyc;
                rise_cyc  = cyc;
                check(sdo == 1'b0, "R9 sdo in sync", sdo, 0);
                cap = 1'b1; nb = 0; chk_fall = 1'b1;
            end else if (cap) begin
                word = {word[W-2:0], sdo};
                nb++;
                if (nb == W) begin
                    cap = 1'b0;
                    if (sb.size() == 0) begin
                        check(1'b0, "R3 unexpected word", word, 0);
                    end else begin
                        x = sb.pop_front();
                        check(word == x.d, "R3 word", word, x.d);
                        check(underrun == x.u, "R7 underrun", underrun, x.u);
                    end
                end
            end else begin
                check(sdo == 1'b0, "R9 idle sdo", sdo, 0);
            end
            fs_prev = fsync;
        end
    end

    // driver
    initial begin
        int n;
        int t0;
        logic [W-1:0] last;
        logic [W-1:0] pats [8] = '{16'h1234, 16'h8000, 16'h0001, 16'h0, 16'h0, 16'hFFFF, 16'h0000, 16'hC3A5};
        repeat (5) @(negedge clk);
        check(sdo == 1'b0, "R8 reset sdo", sdo, 0);
        check(fsync == 1'b0, "R8 reset fsync", fsync, 0);
        check(underrun == 1'b0, "R8 reset underrun", underrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fsync == 1'b0 && underrun == 1'b0, "R8 after reset", fsync, 0);

        load_word(16'hA53C);
        last = 16'hA53C;
        pwr_dig = 1'b1;
        repeat (3 * F) @(negedge clk);
        check(fs_count == 0, "R4 digital only", fs_count, 0);
        pwr_dig = 1'b0; pwr_ana = 1'b1;
        repeat (3 * F) @(negedge clk);
        check(fs_count == 0, "R4 analog only", fs_count, 0);

        pwr_dig = 1'b1;
        t0 = cyc; n = fs_count;
        wait (fs_count > n);
        check((rise_cyc - t0 > (S - 1) * F) && (rise_cyc - t0 <= S * F + 4),
              "R5 start-up delay", rise_cyc - t0, S * F);
        period_en = 1'b1;

        for (int i = 0; i < 8; i++) begin
            if (i == 3 || i == 4) sb.push_back('{d: last, u: 1'b1});
            else begin
                load_word(pats[i]);
                last = pats[i];
            end
            n = fs_count;
            wait (fs_count > n);
        end
        // word of the last frame is on the line: stop now (R6)
        pwr_ana = 1'b0;
        period_en = 1'b0;
        n = fs_count;
        repeat (4 * F) @(negedge clk);
        check(sb.size() == 0, "R6 word completed", sb.size(), 0);
        check(fs_count == n, "R6 no further frames", fs_count - n, 0);

        load_word(16'h5AA5);
        pwr_ana = 1'b1;
        t0 = cyc; n = fs_count;
        wait (fs_count > n);
        check((rise_cyc - t0 > (S - 1) * F) && (rise_cyc - t0 <= S * F + 4),
              "R6 restart delay", rise_cyc - t0, S * F);
        repeat (3 * W + 8) @(negedge clk);
        check(sb.size() == 0, "R7 restart word sent", sb.size(), 0);
        pwr_dig = 1'b0;
        repeat (2 * F) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule